// File: doc/BRIEF.md
# Real-Time Clock Host Register Bank

This block is the register bank that a host sees in a PC-style real-time clock. The host reaches it through four byte ports chosen by a 2-bit port select. A main index port and its data port reach the lower 128 locations. An extended index port and its data port reach the upper 128 locations. Four locations in the lower bank are control registers with their own rules. The rest are plain battery-backed storage.

The timing blocks around the bank read the control fields it exports: rate select, divider control, data format, hour format, set mode and the three interrupt enables. They report events through three flag-set strobes, which land in status register C and raise a level interrupt. The host clears that interrupt by reading register C. An update sequencer supplies the update-in-progress bit. Calendar arithmetic and timers live outside this block.

There are two resets. Power-on reset (`por_n`, asynchronous, active low) loads the initial control values. The synchronous system reset (`soft_rst`) applies only the partial clearing that a platform reset requires.

Top module: `rtc_regbank`

## Requirements
- R1: `port_sel` encodes 0 = main index, 1 = main data, 2 = extended index, 3 = extended data. A write to the main index keeps only value bits 6..0, so 0x90 selects location 0x10. A read of either index port returns 0xFF.
- R2: A write to the extended index stores the value with bit 7 forced to 1. The extended data port therefore reaches only 0x80..0xFF, and extended location 0x90 is distinct from main location 0x10.
- R3: A data read of register C (0x0C) returns its current value. From the next cycle on, C reads 0x00 and `irq_o` is low, unless a flag strobe arrives in that same cycle.
- R4: Data writes to register C (0x0C) and register D (0x0D) change nothing: C and D read back their previous values.
- R5: A write to register A (0x0A) stores value bits 6..0. A read of A returns `uip_i` in bit 7. `rate_sel_o` is A[3:0] and `div_ctl_o` is A[6:4].
- R6: A write to register B (0x0B) always stores bit 3 as 0. If the written bit 7 (set mode) is 1, bit 4 (update interrupt enable) is stored as 0. The outputs map B as bit 0 `dst_en_o`, bit 1 `hour24_o`, bit 2 `bin_mode_o`, bit 4 `uie_o`, bit 5 `aie_o`, bit 6 `pie_o`, bit 7 `set_mode_o`.
- R7: `soft_rst` clears B bits 6..4, clears C and drops `irq_o`, and returns the main index to 0. It leaves A, D and storage unchanged.
- R8: After power-on reset, A reads 0x26 (with `uip_i` low), B reads 0x02, C reads 0x00 and D reads 0x80.
- R9: A data write to location 0x37 also writes the same value to location 0x32. A write to 0x32 does not touch 0x37.
- R10: `flag_set` bit 2 (periodic) sets C bit 6, bit 1 (alarm) sets C bit 5, and bit 0 (update) sets C bit 4. Any strobe also sets C bit 7 and raises `irq_o`, which stays high until C is read. A strobe in the same cycle as a C read survives the clear.
- R11: Every other location in either bank reads back the last value written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| soft_rst | input | 1 | Synchronous system reset, active high |
| port_sel | input | 2 | Host port select (see R1) |
| wr_en | input | 1 | Host write strobe, one cycle per byte |
| rd_en | input | 1 | Host read strobe, one cycle per byte |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Host read data, valid in the cycle of `rd_en` |
| uip_i | input | 1 | Update-in-progress from the update sequencer |
| flag_set | input | 3 | Flag-set strobes: periodic, alarm, update |
| irq_o | output | 1 | Level interrupt request |
| rate_sel_o | output | 4 | Periodic rate select |
| div_ctl_o | output | 3 | Divider chain control |
| set_mode_o | output | 1 | Set mode (time copy frozen) |
| pie_o | output | 1 | Periodic interrupt enable |
| aie_o | output | 1 | Alarm interrupt enable |
| uie_o | output | 1 | Update interrupt enable |
| bin_mode_o | output | 1 | Binary data format |
| hour24_o | output | 1 | 24-hour format |
| dst_en_o | output | 1 | Daylight saving enable |

## Verification
The bench drives a flag strobe into the very cycle of a register C read. A design that lets the clear win loses that event and leaves the interrupt low. It writes 0xFF to register B and checks that set mode strips both bit 3 and bit 4; a design that masks only one shows the wrong byte. It also aliases index values across the two banks and applies the system reset with non-zero control fields. A missing index mask, an unforced extended bit 7, or a reset that touches A or D each shows up as a wrong readback.

// File: rtl/rtc_regbank_pkg.sv
package rtc_regbank_pkg;
  localparam int DW = 8;
  localparam int AW = 8;
  localparam int DEPTH = 1 << AW;

  localparam logic [AW-1:0] ADDR_A     = 8'h0A;
  localparam logic [AW-1:0] ADDR_B     = 8'h0B;
  localparam logic [AW-1:0] ADDR_C     = 8'h0C;
  localparam logic [AW-1:0] ADDR_D     = 8'h0D;
  localparam logic [AW-1:0] ADDR_CENT  = 8'h32;
  localparam logic [AW-1:0] ADDR_CENT2 = 8'h37;

  localparam logic [DW-2:0] A_POR = 7'h26;
  localparam logic [DW-1:0] B_POR = 8'h02;
  localparam logic [DW-1:0] D_VAL = 8'h80;

  typedef enum logic [1:0] {
    PORT_IDX  = 2'd0,
    PORT_DAT  = 2'd1,
    PORT_XIDX = 2'd2,
    PORT_XDAT = 2'd3
  } port_e;

  // Register B host-write rule: bit 3 never stored, set mode kills bit 4.
  function automatic logic [DW-1:0] b_write_mask(input logic [DW-1:0] v);
    logic [DW-1:0] r;
    r = v & 8'hF7;
    if (v[7]) r[4] = 1'b0;
    return r;
  endfunction

  // System reset keeps only bit 7 and bits 3..0 of register B.
  function automatic logic [DW-1:0] b_reset_mask(input logic [DW-1:0] v);
    return v & 8'h8F;
  endfunction

  // Strobes {periodic, alarm, update} map to C bits 6..4; any one sets bit 7.
  function automatic logic [DW-1:0] c_flags(input logic [2:0] s);
    return {|s, s, 4'b0000};
  endfunction
endpackage

// File: rtl/rtc_idx_decode.sv
module rtc_idx_decode
  import rtc_regbank_pkg::*;
(
  input  logic          clk,
  input  logic          por_n,
  input  logic          soft_rst,
  input  logic [1:0]    port_sel,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [DW-1:0] wdata,
  output logic [AW-1:0] acc_addr,
  output logic          dat_wr,
  output logic          dat_rd
);
  localparam logic [AW-1:0] XIDX_RST = {1'b1, {(AW-1){1'b0}}};

  logic [AW-2:0] main_idx;
  logic [AW-1:0] ext_idx;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      main_idx <= '0;
      ext_idx  <= XIDX_RST;
    end else if (soft_rst) begin
      main_idx <= '0;
      ext_idx  <= XIDX_RST;
    end else if (wr_en) begin
      if (port_sel == PORT_IDX)  main_idx <= wdata[AW-2:0];
      if (port_sel == PORT_XIDX) ext_idx  <= {1'b1, wdata[AW-2:0]};
    end
  end

  assign acc_addr = port_sel[1] ? ext_idx : {1'b0, main_idx};
  assign dat_wr   = wr_en & port_sel[0];
  assign dat_rd   = rd_en & port_sel[0];

  // R2: the extended data port never reaches the lower bank
  assert_ext_upper_R2: assert property (@(posedge clk) disable iff (!por_n)
    (port_sel == PORT_XDAT) |-> acc_addr[AW-1]);
endmodule

// File: rtl/rtc_ctrl_regs.sv
module rtc_ctrl_regs
  import rtc_regbank_pkg::*;
(
  input  logic          clk,
  input  logic          por_n,
  input  logic          soft_rst,
  input  logic [AW-1:0] acc_addr,
  input  logic          dat_wr,
  input  logic          dat_rd,
  input  logic [DW-1:0] wdata,
  input  logic          uip_i,
  input  logic [2:0]    flag_set,
  output logic          is_ctrl,
  output logic [DW-1:0] ctrl_rdata,
  output logic          irq_o,
  output logic [DW-2:0] a_q,
  output logic [DW-1:0] b_q
);
  logic [DW-1:0] c_q;
  logic [DW-1:0] d_q;
  logic hit_a, hit_b, hit_c, hit_d;
  logic a_wr, b_wr, c_rd, cd_wr;
  logic [DW-1:0] set_bits;

  assign hit_a    = (acc_addr == ADDR_A);
  assign hit_b    = (acc_addr == ADDR_B);
  assign hit_c    = (acc_addr == ADDR_C);
  assign hit_d    = (acc_addr == ADDR_D);
  assign is_ctrl  = hit_a | hit_b | hit_c | hit_d;
  assign a_wr     = dat_wr & hit_a;
  assign b_wr     = dat_wr & hit_b;
  assign c_rd     = dat_rd & hit_c;
  assign cd_wr    = dat_wr & (hit_c | hit_d);
  assign set_bits = c_flags(flag_set);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      a_q <= A_POR;
    end else if (a_wr) begin
      a_q <= wdata[DW-2:0];
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      b_q <= B_POR;
    end else if (soft_rst) begin
      b_q <= b_reset_mask(b_q);
    end else if (b_wr) begin
      b_q <= b_write_mask(wdata);
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      c_q <= '0;
    end else if (soft_rst) begin
      c_q <= '0;
    end else if (c_rd) begin
      c_q <= set_bits;
    end else begin
      c_q <= c_q | set_bits;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) d_q <= D_VAL;
  end

  assign irq_o = c_q[7];

  always_comb begin
    ctrl_rdata = '0;
    if (hit_a) ctrl_rdata = {uip_i, a_q};
    if (hit_b) ctrl_rdata = b_q;
    if (hit_c) ctrl_rdata = c_q;
    if (hit_d) ctrl_rdata = d_q;
  end

  assert_c_read_clears_R3: assert property (@(posedge clk) disable iff (!por_n)
    (c_rd && flag_set == 3'b000) |=> (c_q == '0 && !irq_o));

  assert_cd_write_ignored_R4: assert property (@(posedge clk) disable iff (!por_n)
    (cd_wr && !soft_rst && flag_set == 3'b000) |=> ($stable(c_q) && $stable(d_q)));

  assert_a_write_R5: assert property (@(posedge clk) disable iff (!por_n)
    a_wr |=> (a_q == $past(wdata[DW-2:0])));

  assert_set_kills_uie_R6: assert property (@(posedge clk) disable iff (!por_n)
    (b_wr && wdata[7] && !soft_rst) |=> (!b_q[4] && !b_q[3]));

  assert_soft_rst_R7: assert property (@(posedge clk) disable iff (!por_n)
    soft_rst |=> (!irq_o && b_q[6:4] == 3'b000));

  assert_strobe_irq_R10: assert property (@(posedge clk) disable iff (!por_n)
    ((|flag_set) && !soft_rst) |=> irq_o);

  assert_irq_holds_R10: assert property (@(posedge clk) disable iff (!por_n)
    (irq_o && !c_rd && !soft_rst) |=> irq_o);
endmodule

// File: rtl/rtc_ram_bank.sv
module rtc_ram_bank
  import rtc_regbank_pkg::*;
(
  input  logic          clk,
  input  logic          por_n,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];
  logic mirror_hit;

  assign mirror_hit = (addr == ADDR_CENT2);

  always_ff @(posedge clk) begin
    if (we) begin
      mem[addr] <= wdata;
      if (mirror_hit) mem[ADDR_CENT] <= wdata;
    end
  end

  assign rdata = mem[addr];

  assert_century_mirror_R9: assert property (@(posedge clk) disable iff (!por_n)
    (we && mirror_hit) |=> (mem[ADDR_CENT] == $past(wdata)));
endmodule

// File: rtl/rtc_regbank.sv
module rtc_regbank
  import rtc_regbank_pkg::*;
(
  input  logic          clk,
  input  logic          por_n,
  input  logic          soft_rst,
  input  logic [1:0]    port_sel,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata,
  input  logic          uip_i,
  input  logic [2:0]    flag_set,
  output logic          irq_o,
  output logic [3:0]    rate_sel_o,
  output logic [2:0]    div_ctl_o,
  output logic          set_mode_o,
  output logic          pie_o,
  output logic          aie_o,
  output logic          uie_o,
  output logic          bin_mode_o,
  output logic          hour24_o,
  output logic          dst_en_o
);
  logic [AW-1:0] acc_addr;
  logic          dat_wr, dat_rd, is_ctrl;
  logic [DW-1:0] ctrl_rdata, ram_rdata;
  logic [DW-2:0] a_q;
  logic [DW-1:0] b_q;

  rtc_idx_decode u_idx (
    .clk(clk), .por_n(por_n), .soft_rst(soft_rst), .port_sel(port_sel),
    .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata),
    .acc_addr(acc_addr), .dat_wr(dat_wr), .dat_rd(dat_rd)
  );

  rtc_ctrl_regs u_ctrl (
    .clk(clk), .por_n(por_n), .soft_rst(soft_rst), .acc_addr(acc_addr),
    .dat_wr(dat_wr), .dat_rd(dat_rd), .wdata(wdata), .uip_i(uip_i),
    .flag_set(flag_set), .is_ctrl(is_ctrl), .ctrl_rdata(ctrl_rdata),
    .irq_o(irq_o), .a_q(a_q), .b_q(b_q)
  );

  rtc_ram_bank u_ram (
    .clk(clk), .por_n(por_n), .we(dat_wr & ~is_ctrl), .addr(acc_addr),
    .wdata(wdata), .rdata(ram_rdata)
  );

  always_comb begin
    if (!port_sel[0])  rdata = 8'hFF;
    else if (is_ctrl)  rdata = ctrl_rdata;
    else               rdata = ram_rdata;
  end

  assign rate_sel_o = a_q[3:0];
  assign div_ctl_o  = a_q[6:4];
  assign set_mode_o = b_q[7];
  assign pie_o      = b_q[6];
  assign aie_o      = b_q[5];
  assign uie_o      = b_q[4];
  assign bin_mode_o = b_q[2];
  assign hour24_o   = b_q[1];
  assign dst_en_o   = b_q[0];

  // R1: index ports read as all ones
  assert_index_reads_ff_R1: assert property (@(posedge clk) disable iff (!por_n)
    (rd_en && !port_sel[0]) |-> (rdata == 8'hFF));
endmodule

// File: tb/tb_rtc_regbank.sv
module tb_rtc_regbank;
  logic clk = 1'b0;
  logic por_n = 1'b0;
  logic soft_rst = 1'b0;
  logic [1:0] port_sel = 2'd0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic uip_i = 1'b0;
  logic [2:0] flag_set = 3'b000;
  logic irq_o, set_mode_o, pie_o, aie_o, uie_o, bin_mode_o, hour24_o, dst_en_o;
  logic [3:0] rate_sel_o;
  logic [2:0] div_ctl_o;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  rtc_regbank dut (
    .clk(clk), .por_n(por_n), .soft_rst(soft_rst), .port_sel(port_sel),
    .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata), .rdata(rdata),
    .uip_i(uip_i), .flag_set(flag_set), .irq_o(irq_o),
    .rate_sel_o(rate_sel_o), .div_ctl_o(div_ctl_o), .set_mode_o(set_mode_o),
    .pie_o(pie_o), .aie_o(aie_o), .uie_o(uie_o), .bin_mode_o(bin_mode_o),
    .hour24_o(hour24_o), .dst_en_o(dst_en_o)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] p, input logic [7:0] d);
    @(negedge clk);
    port_sel = p; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Drive read; flags may be applied in the same cycle.
  task automatic bus_rd(input logic [1:0] p, input logic [7:0] exp, input string tag,
                        input logic [2:0] fl = 3'b000);
    @(negedge clk);
    port_sel = p; rd_en = 1'b1; flag_set = fl;
    #1 check(tag, rdata, exp);
    @(negedge clk);
    rd_en = 1'b0; flag_set = 3'b000;
  endtask

  // {is_write, port, data, expected read, requirement number}
  localparam int NV = 28;
  localparam logic [22:0] VEC [NV] = '{
    {1'b0, 2'd0, 8'h00, 8'hFF, 4'd1},  // R1 main index reads FF
    {1'b1, 2'd0, 8'h8A, 8'h00, 4'd1},  // R1 0x8A -> index 0x0A
    {1'b0, 2'd1, 8'h00, 8'h26, 4'd8},  // R8 power-up A
    {1'b1, 2'd1, 8'hF3, 8'h00, 4'd5},
    {1'b0, 2'd1, 8'h00, 8'h73, 4'd5},  // R5 bit 7 not stored
    {1'b1, 2'd0, 8'h0B, 8'h00, 4'd8},
    {1'b0, 2'd1, 8'h00, 8'h02, 4'd8},  // R8 power-up B
    {1'b1, 2'd1, 8'hFF, 8'h00, 4'd6},
    {1'b0, 2'd1, 8'h00, 8'hE7, 4'd6},  // R6 set clears bits 3 and 4
    {1'b1, 2'd1, 8'h1C, 8'h00, 4'd6},
    {1'b0, 2'd1, 8'h00, 8'h14, 4'd6},  // R6 bit 3 cleared, bit 4 kept
    {1'b1, 2'd0, 8'h0C, 8'h00, 4'd4},
    {1'b1, 2'd1, 8'hFF, 8'h00, 4'd4},
    {1'b0, 2'd1, 8'h00, 8'h00, 4'd4},  // R4 C write ignored
    {1'b1, 2'd0, 8'h0D, 8'h00, 4'd4},
    {1'b1, 2'd1, 8'h00, 8'h00, 4'd4},
    {1'b0, 2'd1, 8'h00, 8'h80, 4'd4},  // R4 D write ignored
    {1'b1, 2'd0, 8'h37, 8'h00, 4'd9},
    {1'b1, 2'd1, 8'h20, 8'h00, 4'd9},
    {1'b1, 2'd0, 8'h32, 8'h00, 4'd9},
    {1'b0, 2'd1, 8'h00, 8'h20, 4'd9},  // R9 century mirror
    {1'b1, 2'd0, 8'h10, 8'h00, 4'd11},
    {1'b1, 2'd1, 8'h5A, 8'h00, 4'd11},
    {1'b1, 2'd2, 8'h10, 8'h00, 4'd2},  // R2 -> 0x90
    {1'b1, 2'd3, 8'hA5, 8'h00, 4'd2},
    {1'b0, 2'd3, 8'h00, 8'hA5, 4'd2},  // R2 extended location
    {1'b0, 2'd1, 8'h00, 8'h5A, 4'd11}, // R11 main 0x10 untouched
    {1'b0, 2'd2, 8'h00, 8'hFF, 4'd1}   // R1 extended index reads FF
  };

  initial begin
    #200000;
    n_checks++; n_errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    por_n = 1'b1;
    @(negedge clk);
    // R8 power-up fields
    check("R8 rate_sel", {4'h0, rate_sel_o}, 8'h06);
    check("R8 div_ctl", {5'h0, div_ctl_o}, 8'h02);
    check("R8 hour24/bin", {6'h0, hour24_o, bin_mode_o}, 8'h02);
    check("R8 irq", {7'h0, irq_o}, 8'h00);

    foreach (VEC[i]) begin
      logic [22:0] v;
      v = VEC[i];
      if (v[22]) bus_wr(v[21:20], v[19:12]);
      else bus_rd(v[21:20], v[11:4], $sformatf("R%0d vector %0d", v[3:0], i));
    end

    // R1 index masked to 7 bits: 0x90 selects 0x10
    bus_wr(2'd0, 8'h90);
    bus_rd(2'd1, 8'h5A, "R1 masked index");
    // R2 extended 0xFF vs main 0x7F
    bus_wr(2'd2, 8'h7F); bus_wr(2'd3, 8'h11);
    bus_wr(2'd0, 8'h7F); bus_wr(2'd1, 8'h22);
    bus_rd(2'd3, 8'h11, "R2 extended 0xFF");
    bus_rd(2'd1, 8'h22, "R11 main 0x7F");
    // R9 write to 0x32 leaves 0x37
    bus_wr(2'd0, 8'h32); bus_wr(2'd1, 8'h19);
    bus_wr(2'd0, 8'h37);
    bus_rd(2'd1, 8'h20, "R9 no reverse mirror");

    // R5 uip in bit 7 and field outputs
    bus_wr(2'd0, 8'h0A); bus_wr(2'd1, 8'h2B);
    uip_i = 1'b1;
    bus_rd(2'd1, 8'hAB, "R5 uip readback");
    uip_i = 1'b0;
    check("R5 rate_sel", {4'h0, rate_sel_o}, 8'h0B);
    check("R5 div_ctl", {5'h0, div_ctl_o}, 8'h02);

    // R10 periodic strobe, irq held
    @(negedge clk); flag_set = 3'b100;
    @(negedge clk); flag_set = 3'b000;
    repeat (4) @(negedge clk);
    check("R10 irq held", {7'h0, irq_o}, 8'h01);
    bus_wr(2'd0, 8'h0C);
    bus_rd(2'd1, 8'hC0, "R10 periodic flags");
    check("R3 irq cleared", {7'h0, irq_o}, 8'h00);
    bus_rd(2'd1, 8'h00, "R3 C cleared");
    // R10 same-cycle strobe survives read
    bus_rd(2'd1, 8'h00, "R10 read during strobe", 3'b010);
    check("R10 irq after collision", {7'h0, irq_o}, 8'h01);
    bus_rd(2'd1, 8'hA0, "R10 alarm flag kept");
    @(negedge clk); flag_set = 3'b001;
    @(negedge clk); flag_set = 3'b000;
    bus_rd(2'd1, 8'h90, "R10 update flag");

    // R7 system reset
    bus_wr(2'd0, 8'h00); bus_wr(2'd1, 8'h3C);
    bus_wr(2'd0, 8'h0B); bus_wr(2'd1, 8'h7A);
    check("R6 B outputs", {pie_o, aie_o, uie_o, bin_mode_o, hour24_o, dst_en_o, 2'b00}, 8'hE8);
    @(negedge clk); flag_set = 3'b100;
    @(negedge clk); flag_set = 3'b000;
    soft_rst = 1'b1;
    @(negedge clk); soft_rst = 1'b0;
    check("R7 irq", {7'h0, irq_o}, 8'h00);
    bus_rd(2'd1, 8'h3C, "R7 index to 0");
    bus_wr(2'd0, 8'h0B);
    bus_rd(2'd1, 8'h02, "R7 B masked");
    bus_wr(2'd0, 8'h0A);
    bus_rd(2'd1, 8'h2B, "R7 A kept");
    bus_wr(2'd0, 8'h0D);
    bus_rd(2'd1, 8'h80, "R7 D kept");
    bus_wr(2'd0, 8'h0C);
    bus_rd(2'd1, 8'h00, "R7 C cleared");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule